// File: doc/BRIEF.md
# Bus-Master Acquisition Controller

This block is the front end of a shared-bus master on a parallel PCI-style bus. It picks the clock on which the master may start a new transaction. It drives the cycle-framing line (FRAME#) and the initiator-ready line (IRDY#), together with their output enables. It also gives the datapath a one-clock strobe for the address phase. All bus inputs are the values sampled on the current rising edge. They are active low, and each one shows the wired value of the shared line.

There are two ways to start a transaction. The normal way is from an idle bus, where both lines are seen high on the same clock. The other way is fast back-to-back: the master goes straight from its own final data phase into a new address phase, with no idle clock between them. The idle test always uses the live framing line and never a registered copy. Another master can take the bus through a fast back-to-back hand-off, and a delayed copy of the framing line would still show the bus as idle. A short burst of data phases runs until a local last-data flag. A sticky bus-conflict flag records any start made while another agent already held the framing line low.

Top module: `pci_acq_ctrl`

## Requirements
- R1: During reset and on the clock after it, both output enables and the address strobe are 0, both drive values are 1, and the conflict flag is 0. Reset is synchronous and active low.
- R2: From idle, the address phase begins on the next clock if and only if, on the current clock, the enable is 1, a request is pending, grant is 0, the framing line is 1 and the ready line is 1.
- R3: A framing line sampled low blocks a start, even when that same line was high on the clock before, as happens when another master starts fast back-to-back right after its final phase.
- R4: In the address phase the framing drive is 0, the ready drive is 1, both enables are 1, and the address strobe is 1 for exactly one clock.
- R5: While last-data is 0 in the address or a data phase, the next clock is a data phase with both drives at 0. When last-data is 1, the next clock is the final phase: framing drive 1, ready drive 0.
- R6: In the final phase, if fast back-to-back is enabled, the enable is 1, a request is pending, grant is 0, and the bus shows framing 1 with ready 0, the next clock is an address phase.
- R7: A final phase that does not chain goes to one release clock, with both drives at 1 and both enables at 1. On the next clock both enables go to 0, unless the release clock itself meets the idle-start condition of R2.
- R8: If grant goes away while idle, before any framing drive, the block stays idle with both enables at 0.
- R9: The conflict flag is set one clock after entry into an address phase whose start decision saw the framing line low. It stays set until reset. With the live-line start rule it never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_en | input | 1 | Bus-master enable |
| b2b_en | input | 1 | Fast back-to-back enable |
| req | input | 1 | Local request for a transaction |
| last_data | input | 1 | Next phase is the final data phase |
| grant_n | input | 1 | Sampled bus grant, active low |
| cyc_in_n | input | 1 | Sampled framing line, active low |
| rdy_in_n | input | 1 | Sampled initiator-ready line, active low |
| cyc_drv_n | output | 1 | Framing line drive value |
| cyc_oe | output | 1 | Framing line output enable |
| rdy_drv_n | output | 1 | Ready line drive value |
| rdy_oe | output | 1 | Ready line output enable |
| addr_phase | output | 1 | Address-phase strobe to the datapath |
| bus_conflict | output | 1 | Sticky conflict flag |

## Verification
Ending a transaction and starting the next can fall in the same cycle, in two ways. In the final data phase the block can either chain a fast back-to-back address phase or fall to release. In the release clock it can either go idle or start at once. The vector table reaches the final phase and the release clock under each combination of fast back-to-back enable, grant, request and master enable. Each expected drive pattern comes from R5 to R7. A separate sequence replays another master's fast back-to-back hand-off while this block is idle and granted. It checks that no address phase follows and that the conflict flag stays clear.

// File: rtl/acq_pkg.sv
// Package: shared types for the bus-master acquisition controller.
// Holds the sequencer state encoding and the packed bundle of line drives,
// plus a decode function used by the drive stage.
package acq_pkg;

    // Phase of the master sequencer.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DATA  = 3'd2,
        ST_FINAL = 3'd3,
        ST_TURN  = 3'd4
    } acq_state_e;

    // Values put on the two control lines and the datapath strobe.
    typedef struct packed {
        logic cyc_oe;
        logic cyc_n;
        logic rdy_oe;
        logic rdy_n;
        logic strobe;
    } line_drive_s;

    localparam int DRIVE_W = $bits(line_drive_s);

    // Maps a phase to its line drive pattern.
    function automatic line_drive_s drive_of(acq_state_e st);
        line_drive_s d;
        d = '{cyc_oe: 1'b0, cyc_n: 1'b1, rdy_oe: 1'b0, rdy_n: 1'b1, strobe: 1'b0};
        case (st)
            ST_ADDR:  d = '{cyc_oe: 1'b1, cyc_n: 1'b0, rdy_oe: 1'b1, rdy_n: 1'b1, strobe: 1'b1};
            ST_DATA:  d = '{cyc_oe: 1'b1, cyc_n: 1'b0, rdy_oe: 1'b1, rdy_n: 1'b0, strobe: 1'b0};
            ST_FINAL: d = '{cyc_oe: 1'b1, cyc_n: 1'b1, rdy_oe: 1'b1, rdy_n: 1'b0, strobe: 1'b0};
            ST_TURN:  d = '{cyc_oe: 1'b1, cyc_n: 1'b1, rdy_oe: 1'b1, rdy_n: 1'b1, strobe: 1'b0};
            default:  d = '{cyc_oe: 1'b0, cyc_n: 1'b1, rdy_oe: 1'b0, rdy_n: 1'b1, strobe: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/acq_start_qual.sv
// Module: acq_start_qual
// Purely combinational start qualifier. It looks only at lines sampled on
// the current edge, never at a delayed copy, and produces two start
// permissions: one after an idle bus and one for fast back-to-back chaining.
// Assumes every input is already synchronous to the bus clock.
module acq_start_qual (
    input  logic master_en,
    input  logic b2b_en,
    input  logic req,
    input  logic grant_n,
    input  logic cyc_in_n,
    input  logic rdy_in_n,
    output logic idle_go,
    output logic chain_go
);

    logic owner_ok;

    // Local side wants the bus and the arbiter is granting it.
    always_comb owner_ok = master_en & req & ~grant_n;

    // Idle start: both lines high right now (live framing line).
    always_comb idle_go = owner_ok & cyc_in_n & rdy_in_n;

    // Chained start: own final phase seen on the bus, feature enabled.
    always_comb chain_go = owner_ok & b2b_en & cyc_in_n & ~rdy_in_n;

endmodule

// File: rtl/acq_seq.sv
// Module: acq_seq
// Transaction phase sequencer. It walks idle -> address -> data* -> final,
// then either chains into a new address phase or spends one release clock.
// Assumes every data phase completes on the clock it is driven; target
// wait states and terminations are handled elsewhere.
module acq_seq
    import acq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_go,
    input  logic       chain_go,
    input  logic       last_data,
    input  logic       master_en,
    input  logic       b2b_en,
    input  logic       req,
    input  logic       grant_n,
    input  logic       cyc_in_n,
    input  logic       rdy_in_n,
    output acq_state_e state
);

    acq_state_e state_nx;

    // Next-phase selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  state_nx = idle_go ? ST_ADDR : ST_IDLE;
            ST_ADDR:  state_nx = last_data ? ST_FINAL : ST_DATA;
            ST_DATA:  state_nx = last_data ? ST_FINAL : ST_DATA;
            ST_FINAL: state_nx = chain_go ? ST_ADDR : ST_TURN;
            ST_TURN:  state_nx = idle_go ? ST_ADDR : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R2: an address phase reached from idle or release needs a full start condition.
    assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && $past(state) != ST_FINAL) |->
        ($past(master_en) && $past(req) && !$past(grant_n) && $past(cyc_in_n) && $past(rdy_in_n)));

    // R6: an address phase right after the final phase needs fast back-to-back enabled.
    assert_chain_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && $past(state) == ST_FINAL) |-> $past(b2b_en));

    // R7: release always follows a final phase.
    assert_turn_after_final_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN) |-> ($past(state) == ST_FINAL));

endmodule

// File: rtl/acq_drive.sv
// Module: acq_drive
// Decodes the sequencer phase into line drive values, output enables and
// the address strobe. Decoding is taken straight from the phase register,
// so every output changes one clock after the decision that set it.
module acq_drive
    import acq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  acq_state_e state,
    output logic       cyc_drv_n,
    output logic       cyc_oe,
    output logic       rdy_drv_n,
    output logic       rdy_oe,
    output logic       addr_phase
);

    line_drive_s drv;

    // Phase to drive-pattern decode.
    always_comb drv = drive_of(state);

    // Fan the bundle out to the individual pins.
    always_comb begin
        cyc_drv_n  = drv.cyc_n;
        cyc_oe     = drv.cyc_oe;
        rdy_drv_n  = drv.rdy_n;
        rdy_oe     = drv.rdy_oe;
        addr_phase = drv.strobe;
    end

    // R4: the address strobe never lasts two clocks.
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |=> !addr_phase);

    // R5: after a final phase (framing released, ready held) ready is released.
    assert_ready_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_oe && cyc_drv_n && !rdy_drv_n) |=> rdy_drv_n);

    // R1: enables are never on without the framing enable.
    assert_enables_paired_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_oe == cyc_oe);

endmodule

// File: rtl/acq_conflict_mon.sv
// Module: acq_conflict_mon
// Watches each entry into the address phase and compares it with the
// framing line that the start decision sampled. A low line there means two
// masters would drive the bus. STICKY picks a latched flag or a one-clock pulse.
module acq_conflict_mon
    import acq_pkg::*;
#(
    parameter bit STICKY = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  acq_state_e state,
    input  logic       cyc_in_n,
    output logic       conflict
);

    logic cyc_seen_n;
    logic hit;

    // Keep the framing value that the last decision was based on.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_seen_n <= 1'b1;
        else        cyc_seen_n <= cyc_in_n;
    end

    // A start was taken while another agent held the framing line low.
    always_comb hit = (state == ST_ADDR) & ~cyc_seen_n;

    generate
        if (STICKY) begin : g_sticky
            // Latched flag, cleared only by reset.
            always_ff @(posedge clk) begin
                if (!rst_n)   conflict <= 1'b0;
                else if (hit) conflict <= 1'b1;
            end
        end else begin : g_pulse
            // Single-clock indication.
            always_ff @(posedge clk) begin
                if (!rst_n) conflict <= 1'b0;
                else        conflict <= hit;
            end
        end
    endgenerate

    // R9: with the live-line start rule no conflict is ever recorded.
    assert_no_conflict_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !conflict);

endmodule

// File: rtl/pci_acq_ctrl.sv
// Module: pci_acq_ctrl (top)
// Bus-master acquisition controller: qualifies starts on live bus lines,
// sequences address, data, final and release phases, drives the framing
// and ready lines, and flags any start that collides with another master.
// Assumes sampled inputs reflect the wired bus value including own drive.
module pci_acq_ctrl
    import acq_pkg::*;
#(
    parameter bit CONFLICT_STICKY = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_en,
    input  logic b2b_en,
    input  logic req,
    input  logic last_data,
    input  logic grant_n,
    input  logic cyc_in_n,
    input  logic rdy_in_n,
    output logic cyc_drv_n,
    output logic cyc_oe,
    output logic rdy_drv_n,
    output logic rdy_oe,
    output logic addr_phase,
    output logic bus_conflict
);

    logic       idle_go;
    logic       chain_go;
    acq_state_e state;

    acq_start_qual u_qual (
        .master_en (master_en),
        .b2b_en    (b2b_en),
        .req       (req),
        .grant_n   (grant_n),
        .cyc_in_n  (cyc_in_n),
        .rdy_in_n  (rdy_in_n),
        .idle_go   (idle_go),
        .chain_go  (chain_go)
    );

    acq_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle_go   (idle_go),
        .chain_go  (chain_go),
        .last_data (last_data),
        .master_en (master_en),
        .b2b_en    (b2b_en),
        .req       (req),
        .grant_n   (grant_n),
        .cyc_in_n  (cyc_in_n),
        .rdy_in_n  (rdy_in_n),
        .state     (state)
    );

    acq_drive u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .cyc_drv_n  (cyc_drv_n),
        .cyc_oe     (cyc_oe),
        .rdy_drv_n  (rdy_drv_n),
        .rdy_oe     (rdy_oe),
        .addr_phase (addr_phase)
    );

    acq_conflict_mon #(.STICKY(CONFLICT_STICKY)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .cyc_in_n (cyc_in_n),
        .conflict (bus_conflict)
    );

endmodule

// File: tb/test_pci_acq_ctrl.sv
// Bench for pci_acq_ctrl: a table of vectors walked once, then directed
// checks for reset, mid-transaction reset and the conflict flag.
module test_pci_acq_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_en = 1'b0, b2b_en = 1'b0, req = 1'b0, last_data = 1'b0;
    logic grant_n = 1'b1, cyc_in_n = 1'b1, rdy_in_n = 1'b1;
    logic cyc_drv_n, cyc_oe, rdy_drv_n, rdy_oe, addr_phase, bus_conflict;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pci_acq_ctrl i_pci_acq_ctrl (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .b2b_en(b2b_en),
        .req(req), .last_data(last_data), .grant_n(grant_n),
        .cyc_in_n(cyc_in_n), .rdy_in_n(rdy_in_n),
        .cyc_drv_n(cyc_drv_n), .cyc_oe(cyc_oe), .rdy_drv_n(rdy_drv_n),
        .rdy_oe(rdy_oe), .addr_phase(addr_phase), .bus_conflict(bus_conflict)
    );

    // Expected output patterns {cyc_oe, cyc_drv_n, rdy_oe, rdy_drv_n, addr_phase}
    localparam logic [4:0] P_IDLE  = 5'b01010;
    localparam logic [4:0] P_ADDR  = 5'b10111;
    localparam logic [4:0] P_DATA  = 5'b10100;
    localparam logic [4:0] P_FINAL = 5'b11100;
    localparam logic [4:0] P_TURN  = 5'b11110;

    // Vector: {master_en, b2b_en, req, grant_n, cyc_in_n, rdy_in_n, last_data, expected[4:0]}
    localparam int NV = 29;
    localparam logic [11:0] VEC [NV] = '{
        {7'b0010110, P_IDLE},   //  0 R2 enable off
        {7'b1000110, P_IDLE},   //  1 R2 no request
        {7'b1011110, P_IDLE},   //  2 R8 no grant
        {7'b1010010, P_IDLE},   //  3 R3 framing low
        {7'b1010100, P_IDLE},   //  4 R2 ready low
        {7'b1010110, P_ADDR},   //  5 R4 start
        {7'b1010010, P_DATA},   //  6 R5 data
        {7'b1010001, P_FINAL},  //  7 R5 final
        {7'b1010100, P_TURN},   //  8 R7 no chain when disabled
        {7'b1000110, P_IDLE},   //  9 R7 release to idle
        {7'b1010110, P_ADDR},   // 10 R2 start
        {7'b1010011, P_FINAL},  // 11 R5 single phase
        {7'b1110100, P_ADDR},   // 12 R6 chained start
        {7'b1110010, P_DATA},   // 13 R5
        {7'b1110000, P_DATA},   // 14 R5 burst continues
        {7'b1110001, P_FINAL},  // 15 R5
        {7'b1111100, P_TURN},   // 16 R6 no grant, no chain
        {7'b1110110, P_ADDR},   // 17 R7 start from release
        {7'b1110011, P_FINAL},  // 18 R5
        {7'b1100100, P_TURN},   // 19 R6 no request, no chain
        {7'b1100110, P_IDLE},   // 20 R7
        {7'b1110100, P_IDLE},   // 21 R3 other master final phase
        {7'b1110010, P_IDLE},   // 22 R3 other master chains
        {7'b1110000, P_IDLE},   // 23 R3
        {7'b1110100, P_IDLE},   // 24 R3
        {7'b1110110, P_ADDR},   // 25 R2 real idle
        {7'b1110011, P_FINAL},  // 26 R5
        {7'b0110100, P_TURN},   // 27 R6 enable off, no chain
        {7'b1111110, P_IDLE}    // 28 R8 grant lost in release
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1, 4, 10, 25: return "R2";
            3, 21, 22, 23, 24: return "R3";
            5: return "R4";
            6, 7, 11, 13, 14, 15, 18, 26: return "R5";
            12, 16, 19, 27: return "R6";
            8, 9, 17, 20: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [4:0] outs();
        return {cyc_oe, cyc_drv_n, rdy_oe, rdy_drv_n, addr_phase};
    endfunction

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: outputs %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_flag(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: conflict %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic put(logic [6:0] v);
        {master_en, b2b_en, req, grant_n, cyc_in_n, rdy_in_n, last_data} = v;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        put(7'b1010110);
        repeat (3) @(posedge clk);
        #1;
        check("R1", outs(), P_IDLE);
        check_flag("R1", bus_conflict, 1'b0);
        rst_n = 1'b1;
        put(7'b0000110);
        @(posedge clk);
        #1;
        check("R1", outs(), P_IDLE);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            put(VEC[i][11:5]);
            @(posedge clk);
            #1;
            check(tag_of(i), outs(), VEC[i][4:0]);
        end

        // R8: grant flapping while idle never drives the bus
        for (int k = 0; k < 4; k++) begin
            put({4'b1011, 3'b110});
            @(posedge clk);
            #1;
            check("R8", outs(), P_IDLE);
            put({4'b1010, 3'b010});
            @(posedge clk);
            #1;
            check("R8", outs(), P_IDLE);
        end

        // R1: reset in the middle of a burst
        put(7'b1010110);
        @(posedge clk);
        #1;
        check("R4", outs(), P_ADDR);
        put(7'b1010010);
        @(posedge clk);
        #1;
        check("R5", outs(), P_DATA);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", outs(), P_IDLE);
        rst_n = 1'b1;
        put(7'b1000110);
        @(posedge clk);
        #1;
        check("R1", outs(), P_IDLE);

        // R9: no conflict recorded anywhere in the run
        check_flag("R9", bus_conflict, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule